// File: doc/BRIEF.md
# Root Clock Generator Control

This block produces one root clock from a set of up to eight source clocks. Each source is presented as an edge strobe in the system clock domain: one tick marks one edge of that source, so two ticks make one source period. The block picks one source and divides it in half steps. The output clock, the selected source and the divider all live in the system clock domain, so the switching logic can be checked cycle by cycle.

Software programs the block through two word registers. A command register carries the commit request, the root enable, four pending flags and a root-off status bit. A configuration register holds the divider code, the source select and a two-bit mode field that a downstream fractional counter decodes. Configuration writes land in staging storage only. Setting the commit bit copies the staged fields, drains the output low, swaps source and divider, waits for two ticks of the new source and then clears the commit bit. The output opens again during a low phase, so it never carries a runt pulse.

Top module: `rcg_root_top`

## Requirements
- R1: After reset the command register reads 0x8000_0000 (bit 31 root-off status set, all other bits 0), the configuration register reads 0, the root output is low and the mode output is 0.
- R2: The configuration register keeps the divider code in bits 4:0, the source select in bits 10:8 and the mode in bits 13:12. Reads return the staged values with all other bits 0. Command bits 4 (divider), 5 (source) and 6 (mode) are set while that staged field differs from the active one, and bit 7 is set while any of them is set.
- R3: Writing 1 to command bit 0 sets it. It reads 1 until the new configuration is active and then clears by itself. Afterwards the pending flags read 0 if the staging storage was not written again.
- R4: A commit completes within 3000 system cycles whenever the old and new sources are ticking.
- R5: With divider code c of 2 or more, the output period is c+1 source ticks and the output is high for the first ceil((c+1)/2) ticks of each period.
- R6: Divider codes 0 and 1 both give no division: a period of 2 ticks, high for 1.
- R7: The output is low in the cycle the source and divider swap and in the cycle before it. Every high pulse across a switch has the full high width of either the old or the new configuration.
- R8: Command bit 1 is the root enable. While it is 0 the output goes low at the end of its current high phase and stays low, and bit 31 reads 1. A commit still completes while the root is disabled. Setting bit 1 to 1 opens the output at the next low phase and clears bit 31.
- R9: A configuration write made while a commit is pending does not alter that commit. It is applied only by the next commit.
- R10: The mode output takes the staged mode only when a commit completes, never at the configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 command, 1 configuration |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| src_tick | input | N_SRC | One edge strobe per source clock |
| root_clk_o | output | 1 | Divided, gated root clock |
| cnt_mode_o | output | 2 | Active mode field for the fractional counter |

## Verification
The assertions watch four things on every cycle. The output is low around each source swap. The commit bit holds until the switch completes and drops right after it. A disabled root that is off stays off. The mode output moves only while a commit is pending, and every commit completes within its cycle limit. The exact output period and high time for each source and divider code can only be shown by the bench's scenarios, which measure pulses. The same goes for the full width of every pulse across a switch, the per-field pending flags, and a configuration written during a pending commit being held for the next one.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
    localparam int CMD_UPD_BIT   = 0;
    localparam int CMD_EN_BIT    = 1;
    localparam int CMD_DIRTY_LSB = 4;
    localparam int CMD_OFF_BIT   = 31;
    localparam int CFG_DIV_LSB   = 0;
    localparam int CFG_SRC_LSB   = 8;
    localparam int CFG_MODE_LSB  = 12;
    localparam int DIV_W         = 5;
    localparam int SRC_W         = 3;
    localparam int MODE_W        = 2;
    localparam int CNT_W         = DIV_W + 1;
    localparam logic ADDR_CMD    = 1'b0;
    localparam logic ADDR_CFG    = 1'b1;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [SRC_W-1:0]  src;
        logic [DIV_W-1:0]  div;
    } rcg_cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_DRAIN,
        SEQ_SETTLE
    } seq_state_e;

    // output period in source ticks for a half-step divider code
    function automatic logic [CNT_W-1:0] div_period(input logic [DIV_W-1:0] code);
        return (code <= DIV_W'(1)) ? CNT_W'(2) : ({1'b0, code} + CNT_W'(1));
    endfunction

    // ticks spent high at the start of each period (rounded up)
    function automatic logic [CNT_W-1:0] div_high(input logic [CNT_W-1:0] period);
        return (period + CNT_W'(1)) >> 1;
    endfunction
endpackage

// File: rtl/rcg_regs.sv
module rcg_regs
    import rcg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        done,
    input  logic        root_off,
    input  rcg_cfg_t    act,
    output rcg_cfg_t    snap,
    output logic        upd_q,
    output logic        en_q
);
    rcg_cfg_t   stage_q;
    logic [3:0] dirty;
    logic       unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:14], reg_wdata[11], reg_wdata[7:5]};

    always_comb begin
        dirty[0] = stage_q.div  != act.div;
        dirty[1] = stage_q.src  != act.src;
        dirty[2] = stage_q.mode != act.mode;
        dirty[3] = |dirty[2:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            snap    <= '0;
            upd_q   <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            if (done) upd_q <= 1'b0;
            if (reg_wr && reg_addr == ADDR_CMD) begin
                en_q <= reg_wdata[CMD_EN_BIT];
                if (reg_wdata[CMD_UPD_BIT] && !upd_q) begin
                    upd_q <= 1'b1;
                    snap  <= stage_q;
                end
            end
            if (reg_wr && reg_addr == ADDR_CFG) begin
                stage_q.div  <= reg_wdata[CFG_DIV_LSB +: DIV_W];
                stage_q.src  <= reg_wdata[CFG_SRC_LSB +: SRC_W];
                stage_q.mode <= reg_wdata[CFG_MODE_LSB +: MODE_W];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CMD) begin
            reg_rdata[CMD_UPD_BIT]          = upd_q;
            reg_rdata[CMD_EN_BIT]           = en_q;
            reg_rdata[CMD_DIRTY_LSB +: 4]   = dirty;
            reg_rdata[CMD_OFF_BIT]          = root_off;
        end else begin
            reg_rdata[CFG_DIV_LSB +: DIV_W]   = stage_q.div;
            reg_rdata[CFG_SRC_LSB +: SRC_W]   = stage_q.src;
            reg_rdata[CFG_MODE_LSB +: MODE_W] = stage_q.mode;
        end
    end
endmodule

// File: rtl/rcg_div.sv
module rcg_div
    import rcg_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SRC_W-1:0] sel,
    input  logic [DIV_W-1:0] code,
    input  logic             restart,
    output logic             sel_tick,
    output logic             level
);
    localparam int N_PAD = 1 << SRC_W;

    logic [N_PAD-1:0] tick_pad;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] high_len;

    for (genvar i = 0; i < N_PAD; i++) begin : g_pad
        if (i < N_SRC) begin : g_live
            assign tick_pad[i] = src_tick[i];
        end else begin : g_dead
            assign tick_pad[i] = 1'b0;
        end
    end

    assign sel_tick = tick_pad[sel];
    assign period   = div_period(code);
    assign high_len = div_high(period);
    assign level    = cnt_q < high_len;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (sel_tick) begin
            cnt_q <= (cnt_q >= period - CNT_W'(1)) ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/rcg_seq.sv
module rcg_seq
    import rcg_pkg::*;
#(
    parameter int SETTLE_TICKS = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     upd_q,
    input  logic     en_q,
    input  rcg_cfg_t snap,
    input  logic     sel_tick,
    input  logic     level,
    output rcg_cfg_t act,
    output logic     restart,
    output logic     done,
    output logic     gate_q
);
    localparam int ST_W = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;

    seq_state_e      state_q;
    logic [ST_W-1:0] settle_q;
    logic            want_open;

    assign restart   = (state_q == SEQ_DRAIN) && !gate_q;
    assign done      = (state_q == SEQ_SETTLE) && sel_tick &&
                       (settle_q == ST_W'(SETTLE_TICKS - 1));
    assign want_open = en_q && (state_q == SEQ_IDLE) && !upd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            act      <= '0;
            gate_q   <= 1'b0;
            settle_q <= '0;
        end else begin
            // the gate only moves while the divided clock is low
            if (!level) gate_q <= want_open;
            case (state_q)
                SEQ_IDLE: begin
                    if (upd_q) state_q <= SEQ_DRAIN;
                end
                SEQ_DRAIN: begin
                    if (!gate_q) begin
                        act      <= snap;
                        settle_q <= '0;
                        state_q  <= SEQ_SETTLE;
                    end
                end
                SEQ_SETTLE: begin
                    if (done)          state_q  <= SEQ_IDLE;
                    else if (sel_tick) settle_q <= settle_q + ST_W'(1);
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rcg_root_top.sv
module rcg_root_top
    import rcg_pkg::*;
#(
    parameter int N_SRC        = 8,
    parameter int SETTLE_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [N_SRC-1:0]  src_tick,
    output logic              root_clk_o,
    output logic [MODE_W-1:0] cnt_mode_o
);
    rcg_cfg_t act;
    rcg_cfg_t snap;
    logic     upd_q;
    logic     en_q;
    logic     done;
    logic     restart;
    logic     gate_q;
    logic     root_off;
    logic     sel_tick;
    logic     level;

    assign root_off   = !gate_q;
    assign root_clk_o = level && gate_q;
    assign cnt_mode_o = act.mode;

    rcg_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
        .root_off(root_off), .act(act), .snap(snap), .upd_q(upd_q), .en_q(en_q)
    );

    rcg_seq #(.SETTLE_TICKS(SETTLE_TICKS)) u_seq (
        .clk(clk), .rst(rst), .upd_q(upd_q), .en_q(en_q), .snap(snap),
        .sel_tick(sel_tick), .level(level), .act(act), .restart(restart),
        .done(done), .gate_q(gate_q)
    );

    rcg_div #(.N_SRC(N_SRC)) u_div (
        .clk(clk), .rst(rst), .src_tick(src_tick), .sel(act.src),
        .code(act.div), .restart(restart), .sel_tick(sel_tick), .level(level)
    );
endmodule

// File: rtl/rcg_root_chk.sv
module rcg_root_chk #(
    parameter int UPD_LIMIT = 3000
) (
    input logic       clk,
    input logic       rst,
    input logic       root_clk_o,
    input logic [1:0] cnt_mode_o,
    input logic       upd_q,
    input logic       done,
    input logic       en_q,
    input logic       root_off,
    input logic [2:0] act_src
);
    logic [15:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || !upd_q) wait_cnt <= '0;
        else               wait_cnt <= wait_cnt + 16'd1;
    end

    assert_no_runt_R7: assert property (@(posedge clk) disable iff (rst)
        (act_src != $past(act_src)) |-> (!root_clk_o && !$past(root_clk_o)));

    assert_upd_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (upd_q && !done) |=> upd_q);

    assert_upd_clear_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !upd_q);

    assert_off_stays_R8: assert property (@(posedge clk) disable iff (rst)
        (!en_q && root_off) |=> root_off);

    assert_mode_commit_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_mode_o) |-> $past(upd_q));

    assert_commit_bound_R4: assert property (@(posedge clk) disable iff (rst)
        upd_q |-> (wait_cnt < 16'(UPD_LIMIT)));
endmodule

bind rcg_root_top rcg_root_chk u_chk (
    .clk(clk), .rst(rst), .root_clk_o(root_clk_o), .cnt_mode_o(cnt_mode_o),
    .upd_q(upd_q), .done(done), .en_q(en_q), .root_off(root_off),
    .act_src(act.src)
);

// File: tb/tb_rcg_root_top.sv
module tb_rcg_root_top;
    localparam int N_SRC = 8;

    // {source, divider code, expected period in cycles, expected high cycles}
    // source k ticks once every k+1 system cycles
    localparam int VEC [8][4] = '{
        '{0, 0,   2,   1},
        '{0, 1,   2,   1},
        '{0, 2,   3,   2},
        '{1, 3,   8,   4},
        '{2, 4,  15,   9},
        '{3, 7,  32,  16},
        '{7, 31, 256, 128},
        '{5, 6,  42,  24}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic             reg_addr = 1'b0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [N_SRC-1:0] src_tick = '0;
    logic             root_clk_o;
    logic [1:0]       cnt_mode_o;

    int tests = 0;
    int fails = 0;
    int tcnt = 0;
    int run_len = 0;
    int bad_pulses = 0;
    int allow_a = 1;
    int allow_b = 1;
    bit mon_on = 1'b0;

    rcg_root_top #(.N_SRC(N_SRC)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_tick(src_tick),
        .root_clk_o(root_clk_o), .cnt_mode_o(cnt_mode_o)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        tcnt++;
        for (int k = 0; k < N_SRC; k++) src_tick[k] = ((tcnt % (k + 1)) == 0);
    end

    // pulse-width monitor for glitch-free switching
    always @(negedge clk) begin
        if (root_clk_o) begin
            run_len++;
        end else if (run_len > 0) begin
            if (mon_on && run_len != allow_a && run_len != allow_b) bad_pulses++;
            run_len = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic commit_wait(output int n);
        logic [31:0] v;
        n = 0;
        rd(1'b0, v);
        while (v[0] && n < 4000) begin
            rd(1'b0, v);
            n++;
        end
    endtask

    task automatic measure(output int hi, output int per);
        int n;
        hi = 0;
        n = 0;
        while (root_clk_o && n < 3000) begin @(negedge clk); n++; end
        n = 0;
        while (!root_clk_o && n < 3000) begin @(negedge clk); n++; end
        while (root_clk_o && hi < 3000) begin @(negedge clk); hi++; end
        n = 0;
        while (!root_clk_o && n < 3000) begin @(negedge clk); n++; end
        per = hi + n;
    endtask

    task automatic count_high(input int cycles, output int highs);
        highs = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (root_clk_o) highs++;
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n, hi, per, prev_hi;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(1'b0, v); chk("R1 cmd reset", v, 32'h8000_0000);
        rd(1'b1, v); chk("R1 cfg reset", v, 32'h0);
        chk("R1 root low", {31'b0, root_clk_o}, 32'h0);
        chk("R1 mode", {30'b0, cnt_mode_o}, 32'h0);

        // table walk: R3 R4 R5 R6 R7
        prev_hi = 1;
        mon_on = 1'b1;
        for (int i = 0; i < 8; i++) begin
            allow_a = prev_hi;
            allow_b = VEC[i][3];
            bad_pulses = 0;
            wr(1'b1, (VEC[i][0] << 8) | VEC[i][1]);
            wr(1'b0, 32'h3);
            commit_wait(n);
            chk("R4 commit bound", {31'b0, n <= 3000}, 32'h1);
            rd(1'b0, v);
            chk("R3 upd cleared, clean", v & 32'hF1, 32'h0);
            measure(hi, per);
            if (VEC[i][1] <= 1) begin
                chk("R6 period no-div", per, VEC[i][2]);
                chk("R6 high no-div", hi, VEC[i][3]);
            end else begin
                chk("R5 period", per, VEC[i][2]);
                chk("R5 high", hi, VEC[i][3]);
            end
            chk("R7 no runt pulse", bad_pulses, 0);
            prev_hi = VEC[i][3];
        end

        // R2 staging and per-field dirty flags (active: src 5, div 6, mode 0)
        allow_a = 24; allow_b = 24; bad_pulses = 0;
        wr(1'b1, 32'h0000_0506); rd(1'b0, v); chk("R2 no dirty", v & 32'hF0, 32'h00);
        wr(1'b1, 32'h0000_0509); rd(1'b0, v); chk("R2 div dirty", v & 32'hF0, 32'h90);
        wr(1'b1, 32'h0000_0206); rd(1'b0, v); chk("R2 src dirty", v & 32'hF0, 32'hA0);
        wr(1'b1, 32'h0000_2506); rd(1'b0, v); chk("R2 mode dirty", v & 32'hF0, 32'hC0);
        wr(1'b1, 32'hFFFF_FFFF); rd(1'b1, v); chk("R2 cfg readback", v, 32'h0000_371F);
        rd(1'b0, v); chk("R2 all dirty", v & 32'hF0, 32'hF0);
        measure(hi, per);
        chk("R2 output unchanged by staging", per, 42);

        // R10 mode follows only on commit
        wr(1'b1, 32'h0000_2506);
        chk("R10 mode before commit", {30'b0, cnt_mode_o}, 32'h0);
        wr(1'b0, 32'h3);
        commit_wait(n);
        chk("R10 mode after commit", {30'b0, cnt_mode_o}, 32'h2);
        rd(1'b0, v); chk("R3 clean after mode commit", v & 32'hF1, 32'h0);
        chk("R7 no runt (mode)", bad_pulses, 0);

        // R9 writes during a pending commit are held
        allow_a = 24; allow_b = 16; bad_pulses = 0;
        wr(1'b1, 32'h0000_0702);
        wr(1'b0, 32'h3);
        wr(1'b1, 32'h0000_0103);
        rd(1'b0, v); chk("R3 still pending", v & 32'h1, 32'h1);
        commit_wait(n);
        chk("R4 commit bound slow src", {31'b0, n <= 3000}, 32'h1);
        rd(1'b0, v); chk("R9 held write dirty", v & 32'hF0, 32'hB0);
        measure(hi, per);
        chk("R9 first commit period", per, 24);
        chk("R9 first commit high", hi, 16);
        allow_a = 16; allow_b = 4;
        wr(1'b0, 32'h3);
        commit_wait(n);
        measure(hi, per);
        chk("R9 second commit period", per, 8);
        chk("R9 second commit high", hi, 4);
        chk("R7 no runt (held)", bad_pulses, 0);

        // R8 root enable and status
        allow_a = 4; allow_b = 1; bad_pulses = 0;
        wr(1'b0, 32'h0);
        repeat (20) @(negedge clk);
        rd(1'b0, v); chk("R8 status off", v & 32'h8000_0002, 32'h8000_0000);
        count_high(40, n); chk("R8 stays low", n, 0);
        wr(1'b1, 32'h0);
        wr(1'b0, 32'h1);
        commit_wait(n);
        chk("R8 commit while disabled", {31'b0, n <= 3000}, 32'h1);
        count_high(20, n); chk("R8 low after commit", n, 0);
        rd(1'b0, v); chk("R8 status still off", v & 32'h8000_0001, 32'h8000_0000);
        wr(1'b0, 32'h2);
        repeat (10) @(negedge clk);
        rd(1'b0, v); chk("R8 status on", v & 32'h8000_0002, 32'h2);
        measure(hi, per);
        chk("R8 period after enable", per, 2);
        chk("R8 high after enable", hi, 1);
        chk("R7 no runt (enable)", bad_pulses, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule